// File: doc/BRIEF.md
# Power-Management Event Status and Enable Register Pair

This block holds a 16-bit event status register and a 16-bit event enable register. Together they produce a level-sensitive system control interrupt (SCI). The status register sits at the base I/O address and the enable register two bytes above it. Hardware event pulses set status flags, and those flags stay set until software clears them. Software clears a flag by writing a 1 to its bit. Only some of the flags can be cleared this way. The remaining flags stay set until reset.

The enable register accepts only two of its bits. Every other enable bit always reads 0. A registered interrupt level is raised while some event pair has both its flag and its enable bit set. The level is re-evaluated every cycle, so it falls by itself once the condition goes away.

Access is through a single-cycle request port. The port carries an address, a byte count, a direction and write data. Every request that hits one of the two addresses is acknowledged one cycle later. That acknowledge carries either read data or an error flag. Only 16-bit (2-byte) accesses are accepted.

Top module: `pm_evt_block`

## Requirements
- R1: After synchronous reset, both registers read 0x0000, `sci_level` is 0 and `acc_ack` is 0.
- R2: A 1 on `evt_pulse` bit 0 (timer), 4 (bus master), 5 (global), 8 (power button), 9 (sleep button), 10 (RTC) or 15 (wake) sets that status bit at the next edge, and the bit then stays set. Pulses on any other bit position have no effect, and those status bits always read 0.
- R3: A 2-byte write to the status address clears each of bits 15, 10, 9, 8 and 4 that is written as 1. Bits 0 and 5 ignore the write, and bits written as 0 are left unchanged.
- R4: A 2-byte write to the enable address stores bit 8 (power button) and bit 5 (global) and drops all others. All other enable bits read 0. The enable register changes only on such a write.
- R5: `sci_level` is 1 exactly when, one cycle earlier, some bit in {0, 5, 8, 9, 10} was set in both the status and the enable register. Status bits 4 and 15 never raise it.
- R6: An access whose `acc_size` is not 2 to either register is acknowledged with `acc_err`=1 and `acc_rdata`=0, and it changes no register.
- R7: The status register answers at `BASE_ADDR`, and the enable register answers at `BASE_ADDR`+2. A request to any other address gets no acknowledge and changes nothing.
- R8: If an event pulse and a write-1 clear of the same status bit arrive in the same cycle, the bit remains set.
- R9: A request at a decoded address is acknowledged on the following cycle. A successful read returns the register value from before that edge on `acc_rdata`. `acc_rdata` is 0 whenever the result is not a successful read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Request strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the request |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 16 | Write data |
| evt_pulse | input | 16 | Event pulses, one per status bit position |
| acc_ack | output | 1 | Request acknowledged (registered) |
| acc_err | output | 1 | Acknowledged request had a bad size |
| acc_rdata | output | 16 | Read data, valid with `acc_ack` |
| sci_level | output | 1 | Registered level interrupt |

## Verification
A request or event presented before edge k has its register effect at edge k. Its acknowledge, error flag and read data appear after edge k. The interrupt level that follows from the change appears only after edge k+1. The bench drives inputs on the falling edge and keeps a behavioural reference model that advances on each rising edge. It compares acknowledge, error, read data and interrupt level on every falling edge, so each result is checked in the cycle it becomes due. Directed checks of the interrupt sample both the cycle right after the causing edge, where the old level is still expected, and the cycle after that. This confirms the one-cycle lag rather than just the final level.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W     = 16;
  localparam int ACC_BYTES = 2;
  localparam int SIZE_W    = 3;

  // Flag positions
  localparam int B_TMR  = 0;
  localparam int B_BUS  = 4;
  localparam int B_GLB  = 5;
  localparam int B_PWR  = 8;
  localparam int B_SLP  = 9;
  localparam int B_RTC  = 10;
  localparam int B_WAKE = 15;

  typedef logic [REG_W-1:0] reg_t;

  // Status bits that exist at all
  localparam reg_t ST_EXIST_M = reg_t'((1 << B_TMR) | (1 << B_BUS) | (1 << B_GLB) |
                                       (1 << B_PWR) | (1 << B_SLP) | (1 << B_RTC) |
                                       (1 << B_WAKE));
  // Status bits that software may clear with a 1
  localparam reg_t ST_CLR_M   = reg_t'((1 << B_WAKE) | (1 << B_RTC) | (1 << B_SLP) |
                                       (1 << B_PWR) | (1 << B_BUS));
  // Enable bits that hold a written value
  localparam reg_t EN_WR_M    = reg_t'((1 << B_PWR) | (1 << B_GLB));
  // Pairs that can raise the interrupt
  localparam reg_t SCI_M      = reg_t'((1 << B_TMR) | (1 << B_GLB) | (1 << B_PWR) |
                                       (1 << B_SLP) | (1 << B_RTC));
endpackage

// File: rtl/pm_evt_regif.sv
module pm_evt_regif
  import pm_evt_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  reg_t              acc_wdata,
  input  reg_t              st_q,
  input  reg_t              en_q,
  output reg_t              st_clr,
  output logic              en_we,
  output reg_t              en_wdata,
  output logic              acc_ack,
  output logic              acc_err,
  output reg_t              acc_rdata
);
  localparam logic [ADDR_W-1:0] EN_ADDR = BASE_ADDR + ADDR_W'(2);

  logic hit_st, hit_en, hit_any, size_ok, good;
  logic ack_q, err_q;
  reg_t rdata_q, rd_sel;

  always_comb begin
    hit_st  = acc_valid && (acc_addr == BASE_ADDR);
    hit_en  = acc_valid && (acc_addr == EN_ADDR);
    hit_any = hit_st || hit_en;
    size_ok = (acc_size == SIZE_W'(ACC_BYTES));
    good    = hit_any && size_ok;
    st_clr   = (good && acc_write && hit_st) ? acc_wdata : '0;
    en_we    = good && acc_write && hit_en;
    en_wdata = acc_wdata;
    rd_sel   = hit_st ? st_q : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= hit_any;
      err_q   <= hit_any && !size_ok;
      rdata_q <= (good && !acc_write) ? rd_sel : '0;
    end
  end

  assign acc_ack   = ack_q;
  assign acc_err   = err_q;
  assign acc_rdata = rdata_q;

  assert_ack_due_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (acc_addr == BASE_ADDR || acc_addr == EN_ADDR)) |=> acc_ack);
  assert_no_ack_miss_R7: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && (acc_addr == BASE_ADDR || acc_addr == EN_ADDR)) |=> !acc_ack);
  assert_err_has_ack_R6: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> (acc_ack && acc_rdata == '0));
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
  import pm_evt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  reg_t evt,
  input  reg_t clr,
  output reg_t st_q
);
  reg_t st_r, keep;

  always_comb keep = st_r & ~(clr & ST_CLR_M);

  always_ff @(posedge clk) begin
    if (rst) st_r <= '0;
    else     st_r <= (keep | evt) & ST_EXIST_M;
  end

  assign st_q = st_r;

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    ((evt & ST_EXIST_M) != '0) |=> ((st_r & $past(evt & ST_EXIST_M)) == $past(evt & ST_EXIST_M)));
  assert_fixed_bits_hold_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_r & $past(st_r) & ~ST_CLR_M) == ($past(st_r) & ~ST_CLR_M)));
  assert_evt_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (evt[B_PWR] && clr[B_PWR]) |=> st_r[B_PWR]);
endmodule

// File: rtl/pm_evt_enable.sv
module pm_evt_enable
  import pm_evt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  reg_t wdata,
  output reg_t en_q
);
  reg_t en_r;

  always_ff @(posedge clk) begin
    if (rst)     en_r <= '0;
    else if (we) en_r <= wdata & EN_WR_M;
  end

  assign en_q = en_r;

  assert_en_only_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(en_r));
endmodule

// File: rtl/pm_evt_sci.sv
module pm_evt_sci
  import pm_evt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  reg_t st_q,
  input  reg_t en_q,
  output logic sci
);
  logic sci_r;
  reg_t pend;

  always_comb pend = st_q & en_q & SCI_M;

  always_ff @(posedge clk) begin
    if (rst) sci_r <= 1'b0;
    else     sci_r <= |pend;
  end

  assign sci = sci_r;
endmodule

// File: rtl/pm_evt_block.sv
module pm_evt_block
  import pm_evt_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [15:0]       acc_wdata,
  input  logic [15:0]       evt_pulse,
  output logic              acc_ack,
  output logic              acc_err,
  output logic [15:0]       acc_rdata,
  output logic              sci_level
);
  reg_t st_q, en_q, st_clr, en_wdata;
  logic en_we;

  pm_evt_regif #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regif (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wdata(acc_wdata),
    .st_q(st_q), .en_q(en_q),
    .st_clr(st_clr), .en_we(en_we), .en_wdata(en_wdata),
    .acc_ack(acc_ack), .acc_err(acc_err), .acc_rdata(acc_rdata)
  );

  pm_evt_status u_status (
    .clk(clk), .rst(rst), .evt(evt_pulse), .clr(st_clr), .st_q(st_q)
  );

  pm_evt_enable u_enable (
    .clk(clk), .rst(rst), .we(en_we), .wdata(en_wdata), .en_q(en_q)
  );

  pm_evt_sci u_sci (
    .clk(clk), .rst(rst), .st_q(st_q), .en_q(en_q), .sci(sci_level)
  );

  assert_sci_lag_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sci_level == $past(|(st_q & en_q & SCI_M))));
  assert_sci_reset_R1: assert property (@(posedge clk)
    rst |=> (!sci_level && !acc_ack));
endmodule

// File: tb/pm_evt_block_tb.sv
module pm_evt_block_tb;
  localparam logic [15:0] BASE = 16'h0400;
  localparam logic [15:0] ENA  = 16'h0402;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [2:0]  acc_size = 3'd2;
  logic [15:0] acc_wdata = '0, evt_pulse = '0;
  logic        acc_ack, acc_err, sci_level;
  logic [15:0] acc_rdata;

  int checks = 0, failures = 0;
  bit done = 0, cmp_on = 0;

  always #10 clk = ~clk;

  pm_evt_block u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .evt_pulse(evt_pulse), .acc_ack(acc_ack), .acc_err(acc_err),
    .acc_rdata(acc_rdata), .sci_level(sci_level)
  );

  // Behavioural reference model
  int m_st = 0, m_en = 0, m_rd = 0;
  bit m_ack = 0, m_err = 0, m_sci = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_en <= 0; m_rd <= 0; m_ack <= 0; m_err <= 0; m_sci <= 0;
    end else begin
      bit hs, he, ok;
      int clr;
      hs = acc_valid && acc_addr == BASE;
      he = acc_valid && acc_addr == ENA;
      ok = (hs || he) && acc_size == 3'd2;
      m_ack <= hs || he;
      m_err <= (hs || he) && acc_size != 3'd2;
      m_rd  <= (ok && !acc_write) ? (hs ? m_st : m_en) : 0;
      clr = (ok && acc_write && hs) ? (int'(acc_wdata) & 'h8710) : 0;
      m_st <= ((m_st & ~clr) | int'(evt_pulse)) & 'h8731;
      if (ok && acc_write && he) m_en <= int'(acc_wdata) & 'h0120;
      m_sci <= ((m_st & m_en & 'h0721) != 0);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R9 ack vs model", int'(acc_ack), int'(m_ack));
      chk("R6 err vs model", int'(acc_err), int'(m_err));
      chk("R9 rdata vs model", int'(acc_rdata), m_rd);
      chk("R5 sci vs model", int'(sci_level), int'(m_sci));
    end
  end

  // One access; returns after the response negedge
  task automatic access(bit wr, logic [15:0] a, logic [2:0] sz, logic [15:0] d,
                        logic [15:0] ev);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz;
    acc_wdata = d; evt_pulse = ev;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; evt_pulse = '0;
  endtask

  task automatic rd(logic [15:0] a, int exp, string tag);
    access(1'b0, a, 3'd2, 16'h0, 16'h0);
    chk(tag, int'(acc_rdata), exp);
  endtask

  task automatic pulse(logic [15:0] ev);
    @(negedge clk);
    evt_pulse = ev;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    chk("R1 sci after reset", int'(sci_level), 0);
    chk("R1 ack after reset", int'(acc_ack), 0);
    rd(BASE, 0, "R1 status after reset");
    rd(ENA, 0, "R1 enable after reset");

    // Enable mask
    access(1'b1, ENA, 3'd2, 16'hFFFF, 16'h0);
    rd(ENA, 'h0120, "R4 enable keeps bits 8 and 5");

    // All events
    pulse(16'hFFFF);
    rd(BASE, 'h8731, "R2 all supported flags set");
    chk("R5 sci raised", int'(sci_level), 1);

    // W1C everything
    access(1'b1, BASE, 3'd2, 16'hFFFF, 16'h0);
    rd(BASE, 'h0021, "R3 timer and global survive clear");
    access(1'b1, ENA, 3'd2, 16'h0000, 16'h0);
    @(negedge clk);
    chk("R5 sci low with no enable", int'(sci_level), 0);

    // Bus-master and wake never raise the interrupt
    access(1'b1, ENA, 3'd2, 16'h0100, 16'h0);
    pulse(16'h8010);
    @(negedge clk);
    chk("R5 bus/wake do not raise sci", int'(sci_level), 0);

    // Latency on power button
    pulse(16'h0100);
    chk("R5 sci one cycle late", int'(sci_level), 0);
    @(negedge clk);
    chk("R5 sci after lag", int'(sci_level), 1);

    // Event wins over clear
    access(1'b1, BASE, 3'd2, 16'h0100, 16'h0100);
    rd(BASE, 'h8131, "R8 event beats clear");

    // Clear alone
    access(1'b1, BASE, 3'd2, 16'h0100, 16'h0);
    chk("R5 sci still high one cycle after clear", int'(sci_level), 1);
    @(negedge clk);
    chk("R5 sci drops after clear", int'(sci_level), 0);

    // Bad sizes
    access(1'b1, ENA, 3'd1, 16'h0020, 16'h0);
    chk("R6 err on 1-byte write", int'(acc_err), 1);
    rd(ENA, 'h0100, "R6 enable unchanged after bad size");
    access(1'b0, BASE, 3'd4, 16'h0, 16'h0);
    chk("R6 err on 4-byte read", int'(acc_err), 1);
    chk("R6 rdata zero on error", int'(acc_rdata), 0);

    // Unmapped address
    access(1'b1, BASE + 16'd4, 3'd2, 16'hFFFF, 16'h0);
    chk("R7 no ack off-map", int'(acc_ack), 0);
    rd(BASE, 'h8031, "R7 status untouched by off-map write");
    rd(ENA, 'h0100, "R7 enable untouched by off-map write");

    // Random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      begin
        int r;
        r = int'($urandom_range(0, 9));
        acc_valid = ($urandom_range(0, 2) != 0);
        acc_write = $urandom_range(0, 1) != 0;
        acc_addr  = (r < 4) ? BASE : (r < 8) ? ENA : BASE + 16'd6;
        acc_size  = ($urandom_range(0, 5) == 0) ? 3'd1 : 3'd2;
        acc_wdata = 16'($urandom);
        evt_pulse = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
      end
    end
    @(negedge clk);
    acc_valid = 1'b0; evt_pulse = '0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule